// File: doc/BRIEF.md
# Zero-Bit-Scan Control Level Counter

This block runs beside a four-signal test access port. It adds new control commands without using the data pins. While the selected instruction is BYPASS or IDCODE, it counts empty data-register scans. An empty scan goes from Capture-DR to Exit1-DR and then to Update-DR, and never enters Shift-DR. The count is a control level. The level is frozen, or locked, when a later scan reaches Shift-DR. A standard port sees only ordinary state sequences under a bypass-type instruction, so it is not affected. The functions that each level selects belong to downstream logic.

The block contains its own TAP state machine, clocked by the TAP clock and steered by TMS. It has the sixteen standard states: TEST_LOGIC_RESET, RUN_TEST_IDLE, SELECT_DR, CAPTURE_DR, SHIFT_DR, EXIT1_DR, PAUSE_DR, EXIT2_DR, UPDATE_DR, SELECT_IR, CAPTURE_IR, SHIFT_IR, EXIT1_IR, PAUSE_IR, EXIT2_IR and UPDATE_IR. They follow the usual transitions:
- TEST_LOGIC_RESET goes to RUN_TEST_IDLE on TMS=0.
- RUN_TEST_IDLE and both UPDATE states go to SELECT_DR on TMS=1.
- SELECT_DR goes to SELECT_IR on 1, otherwise to CAPTURE_DR.
- SELECT_IR goes to TEST_LOGIC_RESET on 1, otherwise to CAPTURE_IR.
- CAPTURE and EXIT2 go to SHIFT on 0.
- CAPTURE and SHIFT go to EXIT1 on 1.
- EXIT1 goes to UPDATE on 1, otherwise to PAUSE.
- PAUSE goes to EXIT2 on 1.
- EXIT2 goes to UPDATE on 1.
- UPDATE goes to RUN_TEST_IDLE on 0.

The instruction code input is sampled when the port leaves UPDATE_IR. That decides whether counting is enabled. Entering TEST_LOGIC_RESET selects IDCODE, so it also enables counting.

Top module: `zbs_level_top`

## Requirements
- R1: While trst_n is low, the port is held in TEST_LOGIC_RESET, and ctl_level, level_locked and locked_level are all 0.
- R2: The TAP state machine follows the standard 1149.1 transitions listed above. Five TMS=1 clocks from any state reach TEST_LOGIC_RESET.
- R3: An empty scan (CAPTURE_DR, then EXIT1_DR, then UPDATE_DR) raises ctl_level by one. The new value is visible from the clock edge that enters UPDATE_DR. Counting starts at 0, so n scans give level n.
- R4: A data scan that passes through PAUSE_DR or SHIFT_DR before UPDATE_DR leaves ctl_level unchanged.
- R5: On the edge that enters SHIFT_DR with counting enabled, level_locked goes to 1 and locked_level takes the current ctl_level.
- R6: While level_locked is 1, further empty scans change neither ctl_level nor locked_level.
- R7: ctl_level saturates at 15. Further empty scans at 15 leave it at 15.
- R8: Entering TEST_LOGIC_RESET through TMS clears ctl_level, level_locked and locked_level to 0 and enables counting.
- R9: Entering CAPTURE_IR clears ctl_level, level_locked and locked_level to 0.
- R10: Counting is enabled only after an instruction scan that loads 4'hF (BYPASS) or 4'h1 (IDCODE). Any other code disables counting: empty scans leave the level at 0, and entering SHIFT_DR does not set level_locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | TAP clock |
| trst_n | input | 1 | Asynchronous active-low TAP reset |
| tms | input | 1 | Test mode select, sampled on the rising tck edge |
| ir_code | input | 4 | Instruction code presented at UPDATE_IR |
| ctl_level | output | 4 | Current control level |
| level_locked | output | 1 | The level has been locked by a Shift-DR entry |
| locked_level | output | 4 | Level captured when the lock was taken |

## Verification
A wrong TAP state shows up as a level that fails to rise at the UPDATE_DR entry of an empty scan, or as a lock that is missing in the same cycle SHIFT_DR is entered. Each test therefore samples the outputs one clock after each relevant edge. A stuck enable or a missed clear shows up as a nonzero level or a set lock right after the CAPTURE_IR or TEST_LOGIC_RESET entry. Such a fault is visible within one tck period. A saturation or post-lock fault appears only after the counter reaches 15 or after a lock is taken. For that reason, long scan runs and empty scans after the lock are driven explicitly.

// File: rtl/zbs_level_pkg.sv
package zbs_level_pkg;
    typedef enum logic [3:0] {
        TEST_LOGIC_RESET = 4'd0,
        RUN_TEST_IDLE    = 4'd1,
        SELECT_DR        = 4'd2,
        CAPTURE_DR       = 4'd3,
        SHIFT_DR         = 4'd4,
        EXIT1_DR         = 4'd5,
        PAUSE_DR         = 4'd6,
        EXIT2_DR         = 4'd7,
        UPDATE_DR        = 4'd8,
        SELECT_IR        = 4'd9,
        CAPTURE_IR       = 4'd10,
        SHIFT_IR         = 4'd11,
        EXIT1_IR         = 4'd12,
        PAUSE_IR         = 4'd13,
        EXIT2_IR         = 4'd14,
        UPDATE_IR        = 4'd15
    } tap_state_t;
endpackage

// File: rtl/zbs_tap_fsm.sv
module zbs_tap_fsm
    import zbs_level_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output tap_state_t next_state,
    output logic       from_capture
);
    always_comb begin
        next_state = state;
        unique case (state)
            TEST_LOGIC_RESET: next_state = tms ? TEST_LOGIC_RESET : RUN_TEST_IDLE;
            RUN_TEST_IDLE:    next_state = tms ? SELECT_DR : RUN_TEST_IDLE;
            SELECT_DR:        next_state = tms ? SELECT_IR : CAPTURE_DR;
            CAPTURE_DR:       next_state = tms ? EXIT1_DR  : SHIFT_DR;
            SHIFT_DR:         next_state = tms ? EXIT1_DR  : SHIFT_DR;
            EXIT1_DR:         next_state = tms ? UPDATE_DR : PAUSE_DR;
            PAUSE_DR:         next_state = tms ? EXIT2_DR  : PAUSE_DR;
            EXIT2_DR:         next_state = tms ? UPDATE_DR : SHIFT_DR;
            UPDATE_DR:        next_state = tms ? SELECT_DR : RUN_TEST_IDLE;
            SELECT_IR:        next_state = tms ? TEST_LOGIC_RESET : CAPTURE_IR;
            CAPTURE_IR:       next_state = tms ? EXIT1_IR  : SHIFT_IR;
            SHIFT_IR:         next_state = tms ? EXIT1_IR  : SHIFT_IR;
            EXIT1_IR:         next_state = tms ? UPDATE_IR : PAUSE_IR;
            PAUSE_IR:         next_state = tms ? EXIT2_IR  : PAUSE_IR;
            EXIT2_IR:         next_state = tms ? UPDATE_IR : SHIFT_IR;
            UPDATE_IR:        next_state = tms ? SELECT_DR : RUN_TEST_IDLE;
            default:          next_state = TEST_LOGIC_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state        <= TEST_LOGIC_RESET;
            from_capture <= 1'b0;
        end else begin
            state        <= next_state;
            from_capture <= (state == CAPTURE_DR);
        end
    end

    // R2: Update-DR is reachable only from one of the two DR exit states
    assert_update_dr_entry_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == UPDATE_DR) |-> ($past(state) == EXIT1_DR || $past(state) == EXIT2_DR));

    // R2: Shift-DR is entered only from Capture-DR, Exit2-DR or itself
    assert_shift_dr_entry_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == SHIFT_DR) |-> ($past(state) == CAPTURE_DR || $past(state) == EXIT2_DR
                                 || $past(state) == SHIFT_DR));
endmodule

// File: rtl/zbs_ir_qual.sv
module zbs_ir_qual
    import zbs_level_pkg::*;
#(
    parameter int          IR_W        = 4,
    parameter logic [IR_W-1:0] BYPASS_CODE = '1,
    parameter logic [IR_W-1:0] IDCODE_CODE = 1
)(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state,
    input  tap_state_t      next_state,
    input  logic [IR_W-1:0] ir_code,
    output logic            count_en
);
    logic code_ok;

    always_comb code_ok = (ir_code == BYPASS_CODE) || (ir_code == IDCODE_CODE);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            count_en <= 1'b1;
        end else if (next_state == TEST_LOGIC_RESET) begin
            count_en <= 1'b1;
        end else if (state == UPDATE_IR) begin
            count_en <= code_ok;
        end
    end

    // R10: enable only changes on leaving Update-IR or entering reset
    assert_en_stable_R10: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) != UPDATE_IR && state != TEST_LOGIC_RESET) |-> $stable(count_en));
endmodule

// File: rtl/zbs_level_ctr.sv
module zbs_level_ctr
    import zbs_level_pkg::*;
#(
    parameter int LVL_W = 4
)(
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_t       state,
    input  tap_state_t       next_state,
    input  logic             from_capture,
    input  logic             count_en,
    output logic [LVL_W-1:0] level,
    output logic             locked,
    output logic [LVL_W-1:0] locked_val
);
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    logic clear_now;
    logic empty_scan;
    logic shift_entry;

    always_comb begin
        clear_now   = (next_state == TEST_LOGIC_RESET) || (next_state == CAPTURE_IR);
        empty_scan  = (state == EXIT1_DR) && from_capture && (next_state == UPDATE_DR);
        shift_entry = (next_state == SHIFT_DR) && (state != SHIFT_DR);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            level      <= '0;
            locked     <= 1'b0;
            locked_val <= '0;
        end else if (clear_now) begin
            level      <= '0;
            locked     <= 1'b0;
            locked_val <= '0;
        end else if (count_en && !locked) begin
            if (empty_scan && level != LVL_MAX) begin
                level <= level + 1'b1;
            end
            if (shift_entry) begin
                locked     <= 1'b1;
                locked_val <= level;
            end
        end
    end

    // R6: once locked, the lock and its value persist until a clear
    assert_lock_holds_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (locked && !clear_now) |=> (locked && $stable(locked_val) && $stable(level)));

    // R7: an empty scan at the top value keeps the level at the top
    assert_no_overflow_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (level == LVL_MAX && !clear_now) |=> (level == LVL_MAX));

    // R3: the level never moves by more than one step without a clear
    assert_step_one_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (!clear_now) |=> (level == $past(level) || level == $past(level) + 1'b1));
endmodule

// File: rtl/zbs_level_top.sv
module zbs_level_top
    import zbs_level_pkg::*;
#(
    parameter int              IR_W        = 4,
    parameter int              LVL_W       = 4,
    parameter logic [IR_W-1:0] BYPASS_CODE = '1,
    parameter logic [IR_W-1:0] IDCODE_CODE = 1
)(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic [IR_W-1:0]  ir_code,
    output logic [LVL_W-1:0] ctl_level,
    output logic             level_locked,
    output logic [LVL_W-1:0] locked_level
);
    tap_state_t state;
    tap_state_t next_state;
    logic       from_capture;
    logic       count_en;

    zbs_tap_fsm u_fsm (
        .tck          (tck),
        .trst_n       (trst_n),
        .tms          (tms),
        .state        (state),
        .next_state   (next_state),
        .from_capture (from_capture)
    );

    zbs_ir_qual #(
        .IR_W        (IR_W),
        .BYPASS_CODE (BYPASS_CODE),
        .IDCODE_CODE (IDCODE_CODE)
    ) u_qual (
        .tck        (tck),
        .trst_n     (trst_n),
        .state      (state),
        .next_state (next_state),
        .ir_code    (ir_code),
        .count_en   (count_en)
    );

    zbs_level_ctr #(
        .LVL_W (LVL_W)
    ) u_ctr (
        .tck          (tck),
        .trst_n       (trst_n),
        .state        (state),
        .next_state   (next_state),
        .from_capture (from_capture),
        .count_en     (count_en),
        .level        (ctl_level),
        .locked       (level_locked),
        .locked_val   (locked_level)
    );

    // R10: with counting disabled the level stays at zero and no lock exists
    assert_disabled_idle_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (!count_en) |-> (ctl_level == '0 && !level_locked));

    // R5: sitting in Shift-DR under an enabled instruction implies a lock
    assert_lock_in_shift_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (state == SHIFT_DR && count_en) |-> level_locked);

    // R8: in Test-Logic-Reset everything is cleared
    assert_tlr_clear_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TEST_LOGIC_RESET) |-> (ctl_level == '0 && !level_locked && count_en));
endmodule

// File: tb/zbs_level_top_tb.sv
module zbs_level_top_tb;
    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic [3:0] ir_code = 4'hF;
    logic [3:0] ctl_level;
    logic       level_locked;
    logic [3:0] locked_level;

    int checks = 0;
    int fails  = 0;

    always #5 tck = ~tck;

    zbs_level_top u_dut (
        .tck          (tck),
        .trst_n       (trst_n),
        .tms          (tms),
        .ir_code      (ir_code),
        .ctl_level    (ctl_level),
        .level_locked (level_locked),
        .locked_level (locked_level)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // one TAP clock; called and returning at a falling edge
    task automatic step(input logic t);
        tms = t;
        @(posedge tck);
        @(negedge tck);
    endtask

    task automatic do_reset();
        trst_n = 1'b0;
        tms = 1'b1;
        repeat (2) @(negedge tck);
        trst_n = 1'b1;
        @(negedge tck);
    endtask

    // from Run-Test-Idle or Update-DR: one empty scan, ending in Update-DR
    task automatic empty_scan();
        step(1); step(0); step(1); step(1);
    endtask

    // from RTI: enter Shift-DR, check lock, return to RTI
    task automatic lock_shift(input string tag, input int exp_lvl, input logic exp_lock);
        step(1); step(0); step(0);
        chk({tag, " lock flag"}, level_locked, exp_lock);
        chk({tag, " locked value"}, locked_level, exp_lock ? exp_lvl : 0);
        step(1); step(1); step(0);
    endtask

    task automatic ir_scan(input logic [3:0] code);
        ir_code = code;
        step(1); step(1); step(0);
        chk("R9 clear at capture-ir level", ctl_level, 0);
        chk("R9 clear at capture-ir lock", level_locked, 0);
        step(0); step(1); step(1); step(0);
    endtask

    task automatic t_reset();
        trst_n = 1'b0;
        repeat (2) @(negedge tck);
        chk("R1 reset level", ctl_level, 0);
        chk("R1 reset lock", level_locked, 0);
        chk("R1 reset locked value", locked_level, 0);
        trst_n = 1'b1;
        @(negedge tck);
    endtask

    task automatic t_count(input int n);
        do_reset();
        step(0);
        for (int i = 0; i < n; i++) begin
            empty_scan();
            chk("R3 level after empty scan", ctl_level, i + 1);
            step(0);
        end
        chk("R3 level before lock", ctl_level, n);
        lock_shift("R5", n, 1'b1);
        empty_scan(); step(0);
        empty_scan(); step(0);
        chk("R6 level after lock", ctl_level, n);
        chk("R6 locked value after lock", locked_level, n);
        chk("R6 still locked", level_locked, 1);
    endtask

    task automatic t_pause_path();
        do_reset();
        step(0);
        empty_scan(); step(0);
        step(1); step(0); step(1); step(0); step(1); step(1); step(0);
        chk("R4 pause path ignored", ctl_level, 1);
        empty_scan();
        chk("R2 back-to-back via update-dr", ctl_level, 2);
        empty_scan(); step(0);
        chk("R2 back-to-back count", ctl_level, 3);
    endtask

    task automatic t_saturate();
        do_reset();
        step(0);
        for (int i = 0; i < 17; i++) empty_scan();
        step(0);
        chk("R7 saturation", ctl_level, 15);
        lock_shift("R7 lock at max", 15, 1'b1);
    endtask

    task automatic t_tms_reset();
        do_reset();
        step(0);
        empty_scan(); empty_scan(); step(0);
        lock_shift("R8 pre", 2, 1'b1);
        repeat (5) step(1);
        chk("R8 tlr level", ctl_level, 0);
        chk("R8 tlr lock", level_locked, 0);
        step(0);
        empty_scan(); step(0);
        chk("R8 counting enabled after tlr", ctl_level, 1);
    endtask

    task automatic t_ir_codes();
        do_reset();
        step(0);
        empty_scan(); step(0);
        ir_scan(4'h5);
        empty_scan(); empty_scan(); step(0);
        chk("R10 other code blocks count", ctl_level, 0);
        lock_shift("R10 no lock", 0, 1'b0);
        ir_scan(4'hF);
        empty_scan(); empty_scan(); step(0);
        chk("R10 bypass code counts", ctl_level, 2);
        ir_scan(4'h1);
        empty_scan(); step(0);
        chk("R10 idcode counts", ctl_level, 1);
        lock_shift("R10 idcode lock", 1, 1'b1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge tck);
        t_reset();
        for (int n = 0; n <= 6; n++) t_count(n);
        t_pause_path();
        t_saturate();
        t_tms_reset();
        t_ir_codes();
        finish_run();
    end
endmodule